// File: doc/BRIEF.md
# Pipelined Ternary Sum Tree

This block reduces a vector of trits, each worth -1, 0 or +1, to one signed total. The number of inputs is a parameter and need not be a power of two. The first level of the tree does not treat a trit as a general 2-bit number. Each pair of trits goes straight into a 3-bit value, because the sum of two trits can only be one of five values (-2 to +2). Every later level is an ordinary binary adder level that is one bit wider than the level before it. When a level has an odd number of operands, the leftover operand moves up to the next level unchanged, sign-extended to the wider width.

A register stage may sit after every few levels; a parameter sets how many. The final level is always registered. The valid flag moves through the same registers as the data, so a result leaves the block a fixed number of cycles after its input vector. That number depends only on the input count and the levels-per-stage setting.

A typical use is the neuron accumulation of a ternary network layer. The ternary products arrive here, and the total goes on to a threshold stage that lies outside this block.

Top module: `ternary_sum_tree`

## Requirements
- R1: Each input trit occupies two bits of `in_trits` (trit i at bits 2i+1:2i), coded 00 = 0, 01 = +1, 11 = -1. For every accepted vector, `out_sum` equals the arithmetic sum of all N_IN trit values.
- R2: Each first-level pair result, and a lone leftover trit at that level, is a 3-bit two's-complement value in the range -2..+2.
- R3: `out_sum` is SUM_W = ceil(log2(2*N_IN+1)) bits signed, and every valid result lies in -N_IN..+N_IN.
- R4: `out_valid` repeats `in_valid` exactly LATENCY cycles later, where LATENCY = ceil(ceil(log2 N_IN) / LEVELS_PER_STAGE). With the defaults (192 inputs, 2 levels per stage) this is 4 cycles.
- R5: With a non-power-of-two N_IN, every input position contributes to the sum exactly once, including positions that reach a level as the odd leftover.
- R6: While `rst_n` is low at a clock edge, `out_valid` and `out_sum` are cleared to 0. After reset, no valid result appears until a valid input has passed through the pipeline.
- R7: A new vector can be accepted on every cycle. Back-to-back vectors and vectors separated by idle cycles each produce their own correct sum without affecting each other.
- R8: All inputs at +1 give exactly +N_IN, and all inputs at -1 give exactly -N_IN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks `in_trits` as a vector to sum |
| in_trits | input | 2*N_IN | Packed trit codes, trit i at bits 2i+1:2i |
| out_valid | output | 1 | Marks `out_sum` as a result |
| out_sum | output | SUM_W | Signed two's-complement total |

## Verification
The range assertions assume that the 10 bit pair never appears on a trit. The design reads that pair as zero, but it is not a legal code. They also assume that inputs are known, not X or Z, from the first clock edge, and that reset is held low for at least one edge before any checking starts. The stimulus builds every vector from the three legal codes only. It drives all-zero inputs throughout reset and changes inputs only at the falling clock edge, so every sampled value lies inside the region where the assertions hold.

// File: rtl/ttree_pkg.sv
// Package: shared trit codes and the size helpers used by the tree.
// Assumes: counts are positive; a level count is at least 1.
package ttree_pkg;

    localparam logic [1:0] TRIT_ZERO = 2'b00;
    localparam logic [1:0] TRIT_POS  = 2'b01;
    localparam logic [1:0] TRIT_NEG  = 2'b11;

    // Number of operands left after k halving levels, with odd counts rounded up.
    function automatic int nodes_at(input int n, input int k);
        return (n + (1 << k) - 1) >> k;
    endfunction

    // Number of register stages when a register follows every lps levels and always follows the last level.
    function automatic int stage_count(input int levels, input int lps);
        return (levels + lps - 1) / lps;
    endfunction

endpackage

// File: rtl/trit_pair_level.sv
// First tree level: turns each pair of trit codes into a 3-bit signed sum (-2..+2).
// A lone last trit, when N_TRITS is odd, becomes a 3-bit value on its own.
// Assumes: the code 10 is never driven; it is read as zero.
// Combinational; clk and rst_n are used only by the assertions.
module trit_pair_level
    import ttree_pkg::*;
#(
    parameter int N_TRITS = 4,
    localparam int OUT_CNT = (N_TRITS + 1) / 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2*N_TRITS-1:0]   trits,
    output logic [OUT_CNT*3-1:0]   sums
);

    for (genvar p = 0; p < OUT_CNT; p++) begin : g_pair
        logic [1:0] ta;
        logic [2:0] res;
        assign ta = trits[4*p +: 2];

        if (2*p + 1 < N_TRITS) begin : g_two
            logic [1:0] tb;
            assign tb = trits[4*p+2 +: 2];
            // Count the +1 inputs and the -1 inputs of the pair and subtract.
            always_comb begin
                res = 3'(ta == TRIT_POS) + 3'(tb == TRIT_POS)
                    - 3'(ta == TRIT_NEG) - 3'(tb == TRIT_NEG);
            end
        end else begin : g_one
            // A single trit maps directly into the 3-bit code.
            always_comb begin
                res = 3'(ta == TRIT_POS) - 3'(ta == TRIT_NEG);
            end
        end

        assign sums[3*p +: 3] = res;

        // R2: a pair of trits can never sum outside -2..+2
        a_r2_pair_range: assert property (@(posedge clk) disable iff (!rst_n)
            ($signed(sums[3*p +: 3]) >= -3'sd2) && ($signed(sums[3*p +: 3]) <= 3'sd2));
    end

endmodule

// File: rtl/tree_level.sv
// Generic reduction level: adds neighbouring operands pairwise, producing results one bit wider.
// An odd last operand is passed up with sign extension.
// Assumes: each input is a signed value bounded by +-2^LEVEL.
// Combinational; clk and rst_n are used only by the assertions.
module tree_level #(
    parameter int IN_CNT = 4,
    parameter int IN_W   = 3,
    parameter int LEVEL  = 1,
    localparam int OUT_CNT = (IN_CNT + 1) / 2,
    localparam int OUT_W   = IN_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [IN_CNT*IN_W-1:0]   in_vals,
    output logic [OUT_CNT*OUT_W-1:0] out_vals
);

    for (genvar p = 0; p < OUT_CNT; p++) begin : g_node
        logic [IN_W-1:0] va;
        assign va = in_vals[2*p*IN_W +: IN_W];

        if (2*p + 1 < IN_CNT) begin : g_add
            logic [IN_W-1:0] vb;
            assign vb = in_vals[(2*p+1)*IN_W +: IN_W];
            // Sign-extend both operands and add them.
            assign out_vals[p*OUT_W +: OUT_W] = {va[IN_W-1], va} + {vb[IN_W-1], vb};
        end else begin : g_pass
            // The leftover operand moves up unchanged.
            assign out_vals[p*OUT_W +: OUT_W] = {va[IN_W-1], va};
        end

        // R5: a node after LEVEL+1 halvings covers at most 2^(LEVEL+1) trits
        a_r5_node_bound: assert property (@(posedge clk) disable iff (!rst_n)
            ($signed(out_vals[p*OUT_W +: OUT_W]) >= -(2 ** (LEVEL + 1))) &&
            ($signed(out_vals[p*OUT_W +: OUT_W]) <= (2 ** (LEVEL + 1))));
    end

endmodule

// File: rtl/stage_reg.sv
// Optional pipeline register for a level's data and its valid flag.
// With ENABLE=0 it is a plain pass-through; with ENABLE=1 both are registered.
// Assumes: synchronous active-low reset; data is cleared to zero along with valid.
module stage_reg #(
    parameter int W      = 8,
    parameter bit ENABLE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);

    if (ENABLE) begin : g_reg
        // Capture the data and valid flag on every edge; clear both during reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                out_data  <= '0;
            end else begin
                out_valid <= in_valid;
                out_data  <= in_data;
            end
        end
    end else begin : g_wire
        assign out_valid = in_valid;
        assign out_data  = in_data;
    end

    // R7: whenever a stage marks its data valid, the data is fully known
    a_r7_valid_data_known: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_data));

endmodule

// File: rtl/ternary_sum_tree.sv
// Top level: sums N_IN trits into a signed SUM_W-bit total through a pipelined tree.
// Level 0 packs trit pairs into 3-bit codes, and each later level widens by one bit.
// A register follows every LEVELS_PER_STAGE levels, and one always follows the last level.
// Assumes: N_IN >= 2, LEVELS_PER_STAGE >= 1, and only legal trit codes are driven.
module ternary_sum_tree
    import ttree_pkg::*;
#(
    parameter int N_IN             = 192,
    parameter int LEVELS_PER_STAGE = 2,
    localparam int SUM_W           = $clog2(2 * N_IN + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [2*N_IN-1:0]       in_trits,
    output logic                    out_valid,
    output logic signed [SUM_W-1:0] out_sum
);

    localparam int DEPTH   = $clog2(N_IN);
    localparam int LATENCY = stage_count(DEPTH, LEVELS_PER_STAGE);
    localparam int TOP_W   = DEPTH + 2;

    for (genvar lv = 0; lv < DEPTH; lv++) begin : g_lvl
        localparam int OUT_CNT  = nodes_at(N_IN, lv + 1);
        localparam int OUT_W    = lv + 3;
        localparam bit REG_HERE = (((lv + 1) % LEVELS_PER_STAGE) == 0) || (lv == DEPTH - 1);

        logic [OUT_CNT*OUT_W-1:0] raw;
        logic [OUT_CNT*OUT_W-1:0] lvl_out;
        logic                     vld_in;
        logic                     vld_out;

        if (lv == 0) begin : g_first
            assign vld_in = in_valid;
            trit_pair_level #(.N_TRITS(N_IN)) u_pairs (
                .clk   (clk),
                .rst_n (rst_n),
                .trits (in_trits),
                .sums  (raw)
            );
        end else begin : g_rest
            localparam int IN_CNT = nodes_at(N_IN, lv);
            assign vld_in = g_lvl[lv-1].vld_out;
            tree_level #(.IN_CNT(IN_CNT), .IN_W(OUT_W - 1), .LEVEL(lv)) u_add (
                .clk      (clk),
                .rst_n    (rst_n),
                .in_vals  (g_lvl[lv-1].lvl_out),
                .out_vals (raw)
            );
        end

        stage_reg #(.W(OUT_CNT * OUT_W), .ENABLE(REG_HERE)) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (vld_in),
            .in_data   (raw),
            .out_valid (vld_out),
            .out_data  (lvl_out)
        );
    end

    logic [TOP_W-1:0] root;
    assign root      = g_lvl[DEPTH-1].lvl_out;
    assign out_sum   = $signed(root[SUM_W-1:0]);
    assign out_valid = g_lvl[DEPTH-1].vld_out;

    // R3: a valid total never leaves -N_IN..+N_IN
    a_r3_out_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (($signed(out_sum) >= -N_IN) && ($signed(out_sum) <= N_IN)));

    // R3: truncating the root to SUM_W bits loses no information (the dropped bits are sign copies)
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($signed(root) == $signed(out_sum)));

    // R6: the first cycle after reset is released carries no result
    a_r6_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && (out_sum == '0)));

    // R4: the pipeline has at least one register stage
    initial begin
        a_r4_has_stage: assert (LATENCY >= 1);
    end

endmodule

// File: tb/ternary_sum_tree_bench.sv
// Bench: a behavioural reference (queues of expected valid flags and sums) compared on every clock.
module ternary_sum_tree_bench;

    localparam int N   = 192;
    localparam int LPS = 2;
    localparam int SW  = $clog2(2 * N + 1);
    localparam int LAT = ($clog2(N) + LPS - 1) / LPS;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic [2*N-1:0]       in_trits = '0;
    logic                 out_valid;
    logic signed [SW-1:0] out_sum;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    bit    q_vld[$];
    int    q_sum[$];
    string q_tag[$];

    logic [2*N-1:0] buf_t;

    always #5 clk = ~clk;

    ternary_sum_tree #(.N_IN(N), .LEVELS_PER_STAGE(LPS)) u_ternary_sum_tree (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_trits  (in_trits),
        .out_valid (out_valid),
        .out_sum   (out_sum)
    );

    function automatic int ref_sum(input logic [2*N-1:0] v);
        int s = 0;
        for (int i = 0; i < N; i++) begin
            if (v[2*i +: 2] == 2'b01) s++;
            else if (v[2*i +: 2] == 2'b11) s--;
        end
        return s;
    endfunction

    function automatic logic [1:0] code_of(input int t);
        return (t > 0) ? 2'b01 : ((t < 0) ? 2'b11 : 2'b00);
    endfunction

    // One clock: compare the outputs against the model, then apply the next input.
    task automatic step(input bit v, input string tag);
        bit    ev;
        int    es;
        string et;
        @(negedge clk);
        ev = q_vld.pop_front();
        es = q_sum.pop_front();
        et = q_tag.pop_front();
        compared++;
        if (out_valid !== ev) begin
            mismatched++;
            $display("FAIL R4 (%s): out_valid=%0b expected %0b", et, out_valid, ev);
        end
        if (ev) begin
            compared++;
            if ($signed(out_sum) !== es) begin
                mismatched++;
                $display("FAIL %s: out_sum=%0d expected %0d", et, $signed(out_sum), es);
            end
        end
        in_valid = v;
        in_trits = buf_t;
        q_vld.push_back(v);
        q_sum.push_back(ref_sum(buf_t));
        q_tag.push_back(tag);
    endtask

    task automatic fill_all(input int t);
        for (int i = 0; i < N; i++) buf_t[2*i +: 2] = code_of(t);
    endtask

    initial begin
        buf_t = '0;
        // R6: outputs are cleared while reset is held
        repeat (3) begin
            @(negedge clk);
            compared++;
            if (out_valid !== 1'b0 || out_sum !== '0) begin
                mismatched++;
                $display("FAIL R6: out_valid=%0b out_sum=%0d expected 0/0", out_valid, out_sum);
            end
        end
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < LAT; k++) begin
            q_vld.push_back(1'b0);
            q_sum.push_back(0);
            q_tag.push_back("R6");
        end

        fill_all(0);  step(1'b1, "R1 all zero");
        fill_all(1);  step(1'b1, "R8 all plus");
        fill_all(-1); step(1'b1, "R8 all minus");
        fill_all(1);  step(1'b0, "R4 idle");
        for (int i = 0; i < N; i++) buf_t[2*i +: 2] = code_of((i % 2 == 0) ? 1 : -1);
        step(1'b1, "R1 alternating");
        for (int i = 0; i < N; i++) buf_t[2*i +: 2] = code_of((i % 3 == 2) ? -1 : 1);
        step(1'b1, "R1 two plus one minus");

        // R5: a single +1, then a single -1, at every position, with a bubble every seventh cycle
        for (int i = 0; i < N; i++) begin
            buf_t = '0;
            buf_t[2*i +: 2] = 2'b01;
            step((i % 7) != 6, "R5 single plus");
        end
        for (int i = 0; i < N; i++) begin
            fill_all(1);
            buf_t[2*i +: 2] = 2'b11;
            step(1'b1, "R5 one minus among plus");
        end

        // R7: random vectors with random idle gaps
        for (int n = 0; n < 400; n++) begin
            for (int i = 0; i < N; i++) buf_t[2*i +: 2] = code_of(int'($urandom_range(0, 2)) - 1);
            step($urandom_range(0, 3) != 0, "R7 random");
        end
        // R3: inputs biased towards one sign keep the total near the range edges
        for (int n = 0; n < 50; n++) begin
            for (int i = 0; i < N; i++) buf_t[2*i +: 2] = code_of(($urandom_range(0, 15) == 0) ? 0 : 1);
            step(1'b1, "R3 near max");
            for (int i = 0; i < N; i++) buf_t[2*i +: 2] = code_of(($urandom_range(0, 15) == 0) ? 0 : -1);
            step(1'b1, "R3 near min");
        end

        buf_t = '0;
        for (int k = 0; k < LAT + 2; k++) step(1'b0, "R4 drain");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule